// File: doc/BRIEF.md
# Stepped Post-Divider with Synchronous Output Gate

This block turns a fast input clock into a slower output clock whose ratio is picked by a two-bit code and a low-power request. The divider counts half-periods: a division ratio of `R` makes every output phase last `R` input cycles, so one output period spans `2*R` input cycles. The code `n_sel` picks a base ratio of 1, 2, 4 or 8. When `pwr_dn` is high, that base ratio is multiplied by 16.

The block never applies the factor of 16 in one jump. A step counter in the reference clock domain moves by one position per reference edge, and each position doubles the ratio. Removing `pwr_dn` walks the counter back down the same way. The step position crosses into the fast domain in Gray code. The divider takes a new ratio only at a rising output edge, so every period is whole and keeps a 50% duty cycle.

The output enable is synchronized into the fast domain. It is then sampled only when the divided clock falls, so the gate can never shorten a high pulse. The output is a complementary pair of registered signals.

Top module: `stepped_postdiv`

## Requirements
- R1: With `pwr_dn` low, `n_sel` codes 2'b00, 2'b01, 2'b10 and 2'b11 give ratios 2, 4, 8 and 1. The rising edges of `clk_out_p` are therefore 4, 8, 16 and 2 input cycles apart.
- R2: With `pwr_dn` high, the same codes give ratios 32, 64, 128 and 16, which are rise-to-rise periods of 64, 128, 256 and 32 cycles.
- R3: Raising `pwr_dn` doubles the ratio four times and lowering it halves the ratio four times. Each step takes exactly a factor of two, with one step per rising edge of `ref_clk`.
- R4: `pwr_dn` is sampled only on rising `ref_clk` edges through a two-stage synchronizer, so a pulse that starts and ends between two such edges changes nothing. A new ratio takes effect only at a rising output edge, so every measured period equals exactly `2*R` for some legal `R`.
- R5: Every high phase of `clk_out_p` lasts exactly `R` input cycles.
- R6: While `out_en` is low, `clk_out_p` is held low and `clk_out_n` high. The synchronized enable is taken only as the divided clock falls, so toggling `out_en` never produces a high pulse shorter than `R`.
- R7: While `rst_n` is low (asynchronous, active low), `clk_out_p` is 0 and `clk_out_n` is 1. After release, the output resumes with the selected period.
- R8: `clk_out_n` is the complement of `clk_out_p` at every sampled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk | input | 1 | Fast input clock that is divided |
| ref_clk | input | 1 | Reference clock that paces the power-down steps |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| n_sel | input | 2 | Base ratio code (quasi-static) |
| pwr_dn | input | 1 | Low-power request; multiplies the ratio by 16 in steps |
| out_en | input | 1 | Output enable, active high |
| clk_out_p | output | 1 | Divided clock, true phase |
| clk_out_n | output | 1 | Divided clock, complement phase |

## Verification
The bench builds the block with its default parameters: four steps and two synchronizer stages. These defaults make the full ratio span from 1 to 128 reachable, along with the complete four-position walk in both directions. The reference clock period is 600 fast cycles, which is longer than the slowest output period. Each intermediate ratio therefore shows up as a run of whole periods, so the bench can log it and time it against reference edges. A short low-power pulse placed between reference edges, and enable toggles at a stride that is coprime to the output period, check the synchronizer and gating boundaries directly.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;
  // Largest base log2 ratio among the four codes.
  localparam int unsigned BASE_LOG_MAX = 3;

  // log2 of the base ratio for each select code.
  function automatic logic [2:0] base_log(input logic [1:0] code);
    case (code)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      2'b10:   return 3'd3;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/pdiv_rst_sync.sv
module pdiv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/pdiv_sync.sv
module pdiv_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stage_d;
      if (s == 0) begin : g_first
        always_comb stage_d = d;
      end else begin : g_next
        always_comb stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pdiv_stepper.sv
module pdiv_stepper #(
  parameter int unsigned MAX_STEP    = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned STEP_W     = $clog2(MAX_STEP + 1)
) (
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic              pwr_dn,
  output logic [STEP_W-1:0] step_gray
);
  logic              pd_s;
  logic [STEP_W-1:0] step_q, step_d;
  logic [STEP_W-1:0] gray_q, gray_d;

  pdiv_sync #(.W(1), .STAGES(SYNC_STAGES)) u_pd_sync (
    .clk(ref_clk), .rst_n(rst_n), .d(pwr_dn), .q(pd_s)
  );

  // One position per reference edge toward the requested end.
  always_comb begin
    step_d = step_q;
    if (pd_s && (step_q < STEP_W'(MAX_STEP)))  step_d = step_q + STEP_W'(1);
    else if (!pd_s && (step_q != '0))          step_d = step_q - STEP_W'(1);
    gray_d = step_d ^ (step_d >> 1);
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      gray_q <= '0;
    end else begin
      step_q <= step_d;
      gray_q <= gray_d;
    end
  end

  assign step_gray = gray_q;

  p_single_step_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (step_q == $past(step_q)) || (step_q == $past(step_q) + STEP_W'(1)) ||
    ($past(step_q) == step_q + STEP_W'(1)));
  p_step_bound_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
    step_q <= STEP_W'(MAX_STEP));
  p_gray_one_bit_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $countones(gray_q ^ $past(gray_q)) <= 1);
endmodule

// File: rtl/pdiv_core.sv
module pdiv_core #(
  parameter int unsigned MAX_LOG = 7,
  localparam int unsigned RATIO_W = MAX_LOG + 1,
  localparam int unsigned CNT_W   = (MAX_LOG > 0) ? MAX_LOG : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] tgt_ratio,
  input  logic               en_s,
  output logic               clk_p,
  output logic               clk_n
);
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [RATIO_W-1:0] ratio_q, ratio_d;
  logic               div_q, div_d;
  logic               en_q, en_d;
  logic               p_q, n_q;
  logic               wrap;

  always_comb begin
    wrap    = ({1'b0, cnt_q} == (ratio_q - RATIO_W'(1)));
    cnt_d   = cnt_q + CNT_W'(1);
    div_d   = div_q;
    ratio_d = ratio_q;
    en_d    = en_q;
    if (wrap) begin
      cnt_d = '0;
      div_d = ~div_q;
      if (!div_q) ratio_d = tgt_ratio;  // rising boundary: new ratio for whole period
      else        en_d    = en_s;       // falling boundary: gate may change
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= RATIO_W'(1);
      div_q   <= 1'b0;
      en_q    <= 1'b0;
      p_q     <= 1'b0;
      n_q     <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
      div_q   <= div_d;
      en_q    <= en_d;
      p_q     <= div_d & en_d;
      n_q     <= ~(div_d & en_d);
    end
  end

  assign clk_p = p_q;
  assign clk_n = n_q;

  p_ratio_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ratio_q) |-> $rose(div_q));
  p_gate_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(en_q) |-> $fell(div_q));
  p_ratio_pow2_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ratio_q) == 1);
  p_phase_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cnt_q} < ratio_q);
  p_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clk_p != clk_n);
endmodule

// File: rtl/stepped_postdiv.sv
module stepped_postdiv #(
  parameter int unsigned MAX_STEP    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       fast_clk,
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic [1:0] n_sel,
  input  logic       pwr_dn,
  input  logic       out_en,
  output logic       clk_out_p,
  output logic       clk_out_n
);
  import pdiv_pkg::*;

  localparam int unsigned STEP_W  = $clog2(MAX_STEP + 1);
  localparam int unsigned MAX_LOG = BASE_LOG_MAX + MAX_STEP;
  localparam int unsigned LOG_W   = $clog2(MAX_LOG + 1);
  localparam int unsigned RATIO_W = MAX_LOG + 1;

  logic              ref_rst_n, fast_rst_n;
  logic [STEP_W-1:0] step_gray_r, step_gray_s, step_bin;
  logic              en_s;
  logic [LOG_W-1:0]  tgt_log;
  logic [RATIO_W-1:0] tgt_ratio;

  pdiv_rst_sync #(.STAGES(SYNC_STAGES)) u_ref_rst (
    .clk(ref_clk), .arst_n(rst_n), .srst_n(ref_rst_n)
  );
  pdiv_rst_sync #(.STAGES(SYNC_STAGES)) u_fast_rst (
    .clk(fast_clk), .arst_n(rst_n), .srst_n(fast_rst_n)
  );

  pdiv_stepper #(.MAX_STEP(MAX_STEP), .SYNC_STAGES(SYNC_STAGES)) u_stepper (
    .ref_clk(ref_clk), .rst_n(ref_rst_n), .pwr_dn(pwr_dn), .step_gray(step_gray_r)
  );

  pdiv_sync #(.W(STEP_W + 1), .STAGES(SYNC_STAGES)) u_fast_sync (
    .clk(fast_clk), .rst_n(fast_rst_n),
    .d({out_en, step_gray_r}), .q({en_s, step_gray_s})
  );

  always_comb begin
    step_bin[STEP_W-1] = step_gray_s[STEP_W-1];
    for (int i = int'(STEP_W) - 2; i >= 0; i--)
      step_bin[i] = step_bin[i+1] ^ step_gray_s[i];
    tgt_log   = LOG_W'(base_log(n_sel)) + LOG_W'(step_bin);
    tgt_ratio = RATIO_W'(1) << tgt_log;
  end

  pdiv_core #(.MAX_LOG(MAX_LOG)) u_core (
    .clk(fast_clk), .rst_n(fast_rst_n), .tgt_ratio(tgt_ratio), .en_s(en_s),
    .clk_p(clk_out_p), .clk_n(clk_out_n)
  );
endmodule

// File: tb/stepped_postdiv_bench.sv
module stepped_postdiv_bench;
  localparam int CLK_PERIOD = 10;
  localparam int REF_CYC    = 600;
  localparam int REF_PERIOD = CLK_PERIOD * REF_CYC;
  localparam int WD_LIMIT   = 150000;
  // {pwr_dn, n_sel, expected rise-to-rise period}
  localparam logic [11:0] TBL [8] = '{
    {1'b0, 2'b00, 9'd4},   {1'b0, 2'b01, 9'd8},   {1'b0, 2'b10, 9'd16},  {1'b0, 2'b11, 9'd2},
    {1'b1, 2'b00, 9'd64},  {1'b1, 2'b01, 9'd128}, {1'b1, 2'b10, 9'd256}, {1'b1, 2'b11, 9'd32}
  };

  logic fast_clk = 0, ref_clk = 0, rst_n = 1;
  logic [1:0] n_sel = 2'b00;
  logic pwr_dn = 0, out_en = 1;
  logic clk_out_p, clk_out_n;

  int n_chk = 0, n_bad = 0, wd = 0;
  int cyc = 0, last_rise = 0, last_period = 0, rise_count = 0, high_start = 0;
  int comp_bad = 0, hi_exp = 0, hi_seen = 0;
  bit have_rise = 0, prev_p = 0, chk_high = 0, log_en = 0;
  int log_val [8];
  int log_cyc [8];
  int log_n = 0, log_last = 0;

  stepped_postdiv u_stepped_postdiv (
    .fast_clk(fast_clk), .ref_clk(ref_clk), .rst_n(rst_n), .n_sel(n_sel),
    .pwr_dn(pwr_dn), .out_en(out_en), .clk_out_p(clk_out_p), .clk_out_n(clk_out_n)
  );

  always #(CLK_PERIOD/2) fast_clk = ~fast_clk;
  always #(REF_PERIOD/2) ref_clk = ~ref_clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge fast_clk) begin
    wd++;
    if (wd > WD_LIMIT) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", wd, WD_LIMIT);
      finish_up();
    end
  end

  // Output monitor, sampling away from the active edge.
  always @(negedge fast_clk) begin
    cyc++;
    if (rst_n) begin
      if (clk_out_p == clk_out_n) comp_bad++;
      if (clk_out_p && !prev_p) begin
        if (have_rise) begin
          last_period = cyc - last_rise;
          if (log_en && last_period != log_last && log_n < 8) begin
            log_val[log_n] = last_period;
            log_cyc[log_n] = cyc;
            log_n++;
            log_last = last_period;
          end
        end
        have_rise = 1; last_rise = cyc; rise_count++; high_start = cyc;
      end
      if (!clk_out_p && prev_p && chk_high) begin
        hi_seen++;
        check((cyc - high_start) == hi_exp, "R6 high pulse width", cyc - high_start, hi_exp);
      end
    end else have_rise = 0;
    prev_p = clk_out_p;
  end

  task automatic measure(output int per);
    int c0 = rise_count;
    while (rise_count < c0 + 2) @(posedge fast_clk);
    per = last_period;
  endtask

  task automatic log_walk(input string req, input int first, input bit up);
    int exp = first;
    check(log_n == 4, {req, " step count"}, log_n, 4);
    for (int i = 0; i < 4; i++) begin
      exp = up ? exp * 2 : exp / 2;
      check(log_val[i] == exp, {req, " step period"}, log_val[i], exp);
      if (i > 0) begin
        int gap = log_cyc[i] - log_cyc[i-1];
        check(gap > REF_CYC - 80 && gap < REF_CYC + 80, {req, " step spacing"}, gap, REF_CYC);
      end
    end
  endtask

  initial begin
    int per;
    bit prev_pd;
    int bad;
    #5 rst_n = 0;
    #20;
    check(clk_out_p == 1'b0, "R7 reset p", clk_out_p, 0);
    check(clk_out_n == 1'b1, "R7 reset n", clk_out_n, 1);
    @(negedge fast_clk); rst_n = 1;
    repeat (40) @(posedge fast_clk);

    // R1 / R2 table walk
    prev_pd = 0;
    foreach (TBL[k]) begin
      pwr_dn = TBL[k][11];
      n_sel  = TBL[k][10:9];
      if (TBL[k][11] != prev_pd) #(8 * REF_PERIOD);
      else repeat (REF_CYC) @(posedge fast_clk);
      prev_pd = TBL[k][11];
      measure(per);
      check(per == int'(TBL[k][8:0]), TBL[k][11] ? "R2 period" : "R1 period", per, int'(TBL[k][8:0]));
    end

    // R3 / R4 stepped walk from ratio 1 up to 16 and back
    pwr_dn = 0; n_sel = 2'b11;
    #(8 * REF_PERIOD);
    measure(per);
    check(per == 2, "R1 settle", per, 2);
    log_n = 0; log_last = 2; log_en = 1;
    pwr_dn = 1;
    #(10 * REF_PERIOD);
    log_en = 0;
    log_walk("R3 up", 2, 1);
    log_n = 0; log_last = 32; log_en = 1;
    pwr_dn = 0;
    #(10 * REF_PERIOD);
    log_en = 0;
    log_walk("R3 down", 32, 0);

    // R4: pulse wholly between reference edges is ignored
    log_n = 0; log_last = 2; log_en = 1;
    @(posedge ref_clk);
    #(REF_PERIOD / 4) pwr_dn = 1;
    #100 pwr_dn = 0;
    #(4 * REF_PERIOD);
    log_en = 0;
    check(log_n == 0, "R4 short pulse ignored", log_n, 0);
    measure(per);
    check(per == 2, "R4 period after pulse", per, 2);

    // R5 / R6: enable toggling with ratio 4
    n_sel = 2'b01;
    repeat (REF_CYC) @(posedge fast_clk);
    measure(per);
    check(per == 8, "R5 period", per, 8);
    hi_exp = 4; hi_seen = 0; chk_high = 1;
    for (int t = 0; t < 60; t++) begin
      repeat (7) @(negedge fast_clk);
      out_en = ~out_en;
    end
    out_en = 1;
    repeat (40) @(negedge fast_clk);
    chk_high = 0;
    check(hi_seen > 10, "R6 pulses observed", hi_seen, 11);
    out_en = 0;
    repeat (30) @(negedge fast_clk);
    bad = 0;
    for (int t = 0; t < 40; t++) begin
      @(negedge fast_clk);
      if (clk_out_p !== 1'b0 || clk_out_n !== 1'b1) bad++;
    end
    check(bad == 0, "R6 held low while disabled", bad, 0);
    out_en = 1;
    repeat (30) @(posedge fast_clk);
    measure(per);
    check(per == 8, "R6 period after enable", per, 8);

    // R7: reset in mid-run
    @(posedge fast_clk); #3 rst_n = 0;
    #1;
    check(clk_out_p == 1'b0, "R7 async reset p", clk_out_p, 0);
    check(clk_out_n == 1'b1, "R7 async reset n", clk_out_n, 1);
    repeat (5) @(negedge fast_clk);
    rst_n = 1;
    repeat (30) @(posedge fast_clk);
    measure(per);
    check(per == 8, "R7 period after reset", per, 8);

    check(comp_bad == 0, "R8 complement pair", comp_bad, 0);
    finish_up();
  end
endmodule